// File: doc/BRIEF.md
# Bidirectional Logarithmic Shifter and Rotator

This block is a purely combinational word shifter. An n-bit operand is moved by an unsigned amount from 0 to n-1 in one of six ways: logical, arithmetic or circular movement, towards either end of the word. The result appears together with two flags, overflow and zero, in the same combinational pass.

Only one datapath moves bits, and it moves them towards the least significant end. It has log2(n) stages. The stage tied to amount bit k moves its input by 2^k places when that bit is set and passes it unchanged otherwise.

For a left operation, a row of 2:1 multiplexers reverses the bit order of the operand before the core. A second row reverses the core's output. The bit that enters from the top during non-circular moves is chosen once, before the stages, and every stage uses that same bit.

A three-bit operation code selects the operation. Its bit 2 selects left, bit 1 selects rotate and bit 0 selects arithmetic. The code is applied on a plain input alongside the operand and the amount.

Top module: `bshift_top`

## Requirements
- R1: Code 000 (logical right) returns A moved right by B, with the top B bits zero. For A=0xB5 and B=3, Y is 0x16.
- R2: Code 001 (arithmetic right) returns A moved right by B, with the top B bits equal to A[n-1]. For A=0xB5 and B=3, Y is 0xF6.
- R3: Code 010 (rotate right) returns A moved right by B, with the top B result bits taken from the low B bits of A. For A=0xB5 and B=3, Y is 0xB6.
- R4: Code 100 (logical left) returns A moved left by B, with the low B bits zero. For A=0xB5 and B=3, Y is 0xA8.
- R5: Code 101 (arithmetic left) returns the logical left result with its MSB replaced by A[n-1]. For A=0xB5 and B=3, Y is 0xA8. For A=0xFF and B=7, Y is 0x80.
- R6: Code 110 (rotate left) returns A moved left by B, with the low B result bits taken from the top B bits of A. For A=0xB5 and B=3, Y is 0xAD.
- R7: When bit 1 (rotate) is set, bit 0 (arithmetic) has no effect. Code 011 gives the same result as code 010, and code 111 gives the same result as code 110.
- R8: Overflow is 1 only for code 101. It is 1 exactly when some bit among A[n-2] down to A[n-1-B] differs from A[n-1]. For A=0xB5 and B=3 it is 1. For A=0xFF and B=7 it is 0.
- R9: The zero flag is 1 exactly when Y is all zeros. For A=0x40, B=1 and code 101, Y is 0x00, zero is 1 and overflow is 1.
- R10: With B=0, every code returns Y=A with overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | Operand |
| amt | input | $clog2(WIDTH) | Unsigned shift or rotate amount |
| op | input | 3 | Operation code: bit 2 left, bit 1 rotate, bit 0 arithmetic |
| y | output | WIDTH | Result |
| ovf | output | 1 | Overflow of arithmetic left shift |
| zero | output | 1 | Result is all zeros |

## Verification
The embedded checks sit inside the combinational logic. They are evaluated only when the operand, amount and code carry no unknown bits, so the checks take fully driven inputs for granted. The bench drives every input to a known value before the first sample and holds it there. It applies a new input only on a rising edge of its sampling clock and reads the outputs on the falling edge. An exhaustive sweep over every operand, amount and code at the default width keeps every input pattern inside this assumption.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

   typedef struct packed {
      logic left;
      logic rotate;
      logic arith;
   } bshift_op_t;

   localparam logic [2:0] OP_SRL = 3'b000;
   localparam logic [2:0] OP_SRA = 3'b001;
   localparam logic [2:0] OP_ROR = 3'b010;
   localparam logic [2:0] OP_SLL = 3'b100;
   localparam logic [2:0] OP_SLA = 3'b101;
   localparam logic [2:0] OP_ROL = 3'b110;

endpackage

// File: rtl/bshift_reverse_row.sv
module bshift_reverse_row #(
   parameter int WIDTH = 8
) (
   input  logic             en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bshift_reverse_row: WIDTH must be at least 2");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         assign q[gi] = en ? d[WIDTH-1-gi] : d[gi];
      end
   endgenerate

endmodule

// File: rtl/bshift_right_core.sv
module bshift_right_core #(
   parameter int WIDTH = 8,
   localparam int STAGES = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0]  d,
   input  logic [STAGES-1:0] amt,
   input  logic              rotate,
   input  logic              fill,
   output logic [WIDTH-1:0]  q
);

   generate
      if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("bshift_right_core: WIDTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_v [0:STAGES];

   assign stage_v[0] = d;

   genvar gk, gi;
   generate
      for (gk = 0; gk < STAGES; gk++) begin : g_stage
         localparam int SH = 1 << gk;
         for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            if (gi + SH < WIDTH) begin : g_inner
               assign stage_v[gk+1][gi] = amt[gk] ? stage_v[gk][gi+SH]
                                                  : stage_v[gk][gi];
            end else begin : g_edge
               assign stage_v[gk+1][gi] = !amt[gk] ? stage_v[gk][gi]
                                        : (rotate ? stage_v[gk][gi+SH-WIDTH]
                                                  : fill);
            end
         end
      end
   endgenerate

   assign q = stage_v[STAGES];

   always_comb begin
      if (!$isunknown({d, amt, rotate, fill})) begin
         // R3: a circular move neither loses nor adds set bits.
         p_rotate_keeps_bits_r3: assert (!rotate || $countones(q) == $countones(d))
            else $error("rotate changed the number of set bits");
      end
   end

endmodule

// File: rtl/bshift_flag_unit.sv
module bshift_flag_unit #(
   parameter int WIDTH = 8,
   localparam int AMT_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] a,
   input  logic [AMT_W-1:0] amt,
   input  logic             sla,
   input  logic [WIDTH-1:0] res,
   output logic             ovf,
   output logic             zero
);

   logic [WIDTH-2:0] lost_mask;
   logic [WIDTH-2:0] differs;

   always_comb begin
      for (int i = 0; i < WIDTH - 1; i++) begin
         lost_mask[i] = (i + int'(amt)) >= (WIDTH - 1);
      end
   end

   assign differs = a[WIDTH-2:0] ^ {(WIDTH-1){a[WIDTH-1]}};
   assign ovf     = sla & (|(differs & lost_mask));
   assign zero    = ~(|res);

   always_comb begin
      if (!$isunknown({a, amt, sla})) begin
         // R8: nothing is shifted out when the amount is zero.
         p_no_overflow_r8: assert (amt != '0 || !ovf)
            else $error("overflow with zero amount");
      end
   end

endmodule

// File: rtl/bshift_top.sv
module bshift_top #(
   parameter int WIDTH = 8,
   localparam int AMT_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] a,
   input  logic [AMT_W-1:0] amt,
   input  logic [2:0]       op,
   output logic [WIDTH-1:0] y,
   output logic             ovf,
   output logic             zero
);
   import bshift_pkg::*;

   generate
      if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("bshift_top: WIDTH must be a power of two of at least 2");
      end
   endgenerate

   bshift_op_t       code;
   logic             arith_eff;
   logic             sra;
   logic             sla;
   logic             fill;
   logic [WIDTH-1:0] core_in;
   logic [WIDTH-1:0] core_out;
   logic [WIDTH-1:0] unrev;

   assign code      = bshift_op_t'(op);
   assign arith_eff = code.arith & ~code.rotate;
   assign sra       = arith_eff & ~code.left;
   assign sla       = arith_eff &  code.left;
   assign fill      = sra & a[WIDTH-1];

   bshift_reverse_row #(.WIDTH(WIDTH)) in_row_i (
      .en (code.left),
      .d  (a),
      .q  (core_in)
   );

   bshift_right_core #(.WIDTH(WIDTH)) core_i (
      .d      (core_in),
      .amt    (amt),
      .rotate (code.rotate),
      .fill   (fill),
      .q      (core_out)
   );

   bshift_reverse_row #(.WIDTH(WIDTH)) out_row_i (
      .en (code.left),
      .d  (core_out),
      .q  (unrev)
   );

   assign y = sla ? {a[WIDTH-1], unrev[WIDTH-2:0]} : unrev;

   bshift_flag_unit #(.WIDTH(WIDTH)) flags_i (
      .a    (a),
      .amt  (amt),
      .sla  (sla),
      .res  (y),
      .ovf  (ovf),
      .zero (zero)
   );

   always_comb begin
      if (!$isunknown({a, amt, op})) begin
         p_ovf_only_sla_r8: assert (!ovf || op == OP_SLA)
            else $error("overflow outside arithmetic left");
         p_zero_flag_r9: assert (zero == (y == '0))
            else $error("zero flag disagrees with result");
         p_identity_r10: assert (amt != '0 || (y == a && !ovf))
            else $error("zero amount altered operand");
         p_sign_kept_r5: assert (op != OP_SLA || y[WIDTH-1] == a[WIDTH-1])
            else $error("arithmetic left lost sign");
         p_low_zero_r4: assert (!(code.left && !code.rotate && amt != '0) || !y[0])
            else $error("left shift did not clear lsb");
      end
   end

endmodule

// File: tb/bshift_tb_top.sv
module bshift_tb_top;
   import bshift_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam int AW         = 3;
   localparam int NVEC       = 12;

   // {a, amt, op, expected y, expected ovf, expected zero}
   localparam logic [23:0] VEC [0:NVEC-1] = '{
      {8'hB5, 3'd3, 3'b000, 8'h16, 1'b0, 1'b0},  // R1
      {8'hB5, 3'd3, 3'b001, 8'hF6, 1'b0, 1'b0},  // R2
      {8'hB5, 3'd3, 3'b010, 8'hB6, 1'b0, 1'b0},  // R3
      {8'hB5, 3'd3, 3'b100, 8'hA8, 1'b0, 1'b0},  // R4
      {8'hB5, 3'd3, 3'b101, 8'hA8, 1'b1, 1'b0},  // R5 R8
      {8'hB5, 3'd3, 3'b110, 8'hAD, 1'b0, 1'b0},  // R6
      {8'h81, 3'd1, 3'b011, 8'hC0, 1'b0, 1'b0},  // R7
      {8'hFF, 3'd7, 3'b101, 8'h80, 1'b0, 1'b0},  // R5 R8
      {8'h40, 3'd1, 3'b101, 8'h00, 1'b1, 1'b1},  // R9 R8
      {8'h01, 3'd1, 3'b000, 8'h00, 1'b0, 1'b1},  // R9
      {8'h5A, 3'd0, 3'b010, 8'h5A, 1'b0, 1'b0},  // R10
      {8'hC3, 3'd0, 3'b101, 8'hC3, 1'b0, 1'b0}   // R10
   };

   logic          clk = 1'b0;
   logic [W-1:0]  a;
   logic [AW-1:0] amt;
   logic [2:0]    op;
   logic [W-1:0]  y;
   logic          ovf;
   logic          zero;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bshift_top #(.WIDTH(W)) dut_i (
      .a    (a),
      .amt  (amt),
      .op   (op),
      .y    (y),
      .ovf  (ovf),
      .zero (zero)
   );

   function automatic logic [W+1:0] model(input logic [W-1:0] av,
                                          input int b, input logic [2:0] o);
      logic [W-1:0] r;
      logic ov;
      logic lft, rot, ari;
      lft = o[2];
      rot = o[1];
      ari = o[0] & ~o[1];
      ov  = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (!lft) begin
            if (i + b < W)  r[i] = av[i+b];
            else if (rot)   r[i] = av[i+b-W];
            else            r[i] = ari ? av[W-1] : 1'b0;
         end else begin
            if (i - b >= 0) r[i] = av[i-b];
            else if (rot)   r[i] = av[i-b+W];
            else            r[i] = 1'b0;
         end
      end
      if (lft && ari) begin
         r[W-1] = av[W-1];
         for (int j = W - 1 - b; j <= W - 2; j++)
            if (av[j] != av[W-1]) ov = 1'b1;
      end
      return {r, ov, (r == '0)};
   endfunction

   task automatic check(input string req, input logic [W+1:0] exp);
      checks++;
      if ({y, ovf, zero} !== exp) begin
         errors++;
         $display("FAIL %s a=%h amt=%0d op=%b got y=%h ovf=%b zero=%b expected y=%h ovf=%b zero=%b",
                  req, a, amt, op, y, ovf, zero, exp[W+1:2], exp[1], exp[0]);
      end
   endtask

   task automatic apply(input logic [W-1:0] av, input logic [AW-1:0] bv,
                        input logic [2:0] ov);
      @(posedge clk);
      a   = av;
      amt = bv;
      op  = ov;
      @(negedge clk);
   endtask

   initial begin
      a = '0; amt = '0; op = '0;
      @(negedge clk);
      // Initial state with all-zero inputs: R9 and R10.
      check("R9_R10_init", {8'h00, 1'b0, 1'b1});

      for (int v = 0; v < NVEC; v++) begin
         apply(VEC[v][23:16], VEC[v][15:13], VEC[v][12:10]);
         check("R1_R10_table", VEC[v][9:0]);
      end

      // R7: the arithmetic bit has no effect while the rotate bit is set.
      apply(8'hB5, 3'd3, 3'b111);
      check("R7_rol_arith", {8'hAD, 1'b0, 1'b0});
      apply(8'hB5, 3'd3, 3'b011);
      check("R7_ror_arith", {8'hB6, 1'b0, 1'b0});
      // R8: overflow stays low for the non-arithmetic-left codes.
      apply(8'h40, 3'd1, 3'b100);
      check("R8_sll_no_ovf", {8'h80, 1'b0, 1'b0});
      // R2: arithmetic right fills with the sign bit across the whole word.
      apply(8'h80, 3'd7, 3'b001);
      check("R2_full_fill", {8'hFF, 1'b0, 1'b0});

      // Exhaustive sweep R1 to R10 against the bench's behavioural model.
      for (int o = 0; o < 8; o++)
         for (int b = 0; b < 8; b++)
            for (int x = 0; x < 256; x++) begin
               apply(x[W-1:0], b[AW-1:0], o[2:0]);
               check("R1_R10_sweep", model(x[W-1:0], b, o[2:0]));
            end

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule